// File: doc/BRIEF.md
# Character LCD Controller Core

This block is a synthesizable model of the controller that sits inside a character LCD module, built so that a host-side driver has a cycle-accurate target to talk to. The host drives a parallel bus made of a register select, a read/write line, an enable strobe and eight data lines. The block samples that bus on the system clock. It acts on each falling edge of the enable strobe and decodes the byte as an instruction or as a data access.

Internally it keeps a 7-bit address counter, which is shared between an 80-byte display RAM and a 64-byte glyph RAM. It also keeps the entry-mode, display and interface flags, and a busy timer whose length depends on the class of operation. The host can read a status byte at any time, made of the busy flag and the counter. It can also read the byte at the current address. The panel scan, the font ROM and the analog drive are outside this block.

Top module: `charlcd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (not busy, counter 0), the display, cursor and blink outputs are 0, the counter steps upward, one-line mode is active and the display RAM holds 0x20 everywhere.
- R2: An instruction (select=0, write) is classified by its most significant set bit: bit0 clear, bit1 home, bit2 entry mode (bit1 = step up), bit3 display control (bit2 display, bit1 cursor, bit0 blink), bit4 shift (bit3 = move display instead of cursor, bit2 = right), bit5 function set (bit4 = 8-bit bus, bit3 = two lines, bit2 = tall font), bit6 glyph address, bit7 display address. 0x00 does nothing.
- R3: Clear writes 0x20 into all 80 display RAM cells, sets the counter to 0 and keeps the busy flag high for LONG_CYC cycles.
- R4: Home sets the counter to 0, leaves both RAMs unchanged and is busy for LONG_CYC cycles.
- R5: Entry, display control, shift, function set and address instructions are busy for SHORT_CYC cycles. Data writes and data reads are busy for DATA_CYC cycles. The flag rises two clock edges after the enable falls.
- R6: With select=0 and read, the output is {busy, counter[6:0]} at any time, and such a cycle never starts a busy period.
- R7: The glyph-address instruction loads bits 5:0 into the counter and routes data to the glyph RAM. The display-address instruction loads bits 6:0 and routes data to the display RAM. Write data lands at the counter address, and read data shows the byte at the counter address.
- R8: After every data write or data read, the counter steps up when the entry-mode step bit is 1 and down when it is 0.
- R9: In two-line mode, display-RAM stepping goes up from 0x27 to 0x40 and from 0x67 to 0x00, and down from 0x40 to 0x27 and from 0x00 to 0x67. Line 1 covers 0x00..0x27 and line 2 covers 0x40..0x67.
- R10: In one-line mode, display-RAM stepping covers 0x00..0x4F, going up from 0x4F to 0x00 and down from 0x00 to 0x4F.
- R11: Instructions, data writes and data reads that arrive while the busy flag is 1 are dropped with no effect on the RAMs, the counter or the flags.
- R12: A cursor shift moves the counter by one (right = up) with the same wrap rules and leaves the RAMs unchanged. A display shift leaves the counter unchanged.
- R13: In the glyph RAM the counter wraps within 6 bits, going from 0x3F to 0x00, and its bit 6 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Enable strobe; the access acts on its falling edge |
| bus_din | input | 8 | Byte driven by the host |
| bus_dout | output | 8 | Status or RAM byte while bus_rw is 1, else 0 |
| disp_on | output | 1 | Display enable flag |
| cursor_on | output | 1 | Cursor enable flag |
| blink_on | output | 1 | Cursor blink flag |

## Verification
The bench builds the block with LONG_CYC=40, SHORT_CYC=5 and DATA_CYC=7, so each access costs a few tens of cycles. With those values it can sweep all 80 display cells and all 64 glyph cells, both write and read-back, and follow the counter after every step. Every wrap point in one-line, two-line and glyph mode comes within reach. The short busy lengths also let the bench check the exact cycle where the flag falls for each operation class, and land a second access inside a busy window on purpose.

// File: rtl/charlcd_pkg.sv
// Shared types for the character LCD controller: opcode classes, the
// most-significant-bit decoder and the blank fill code.
package charlcd_pkg;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
        OP_SHIFT, OP_FUNC, OP_GADDR, OP_DADDR
    } op_e;

    localparam logic [7:0] BLANK_CODE = 8'h20;

    // Class of an instruction byte is set by its highest 1 bit.
    function automatic op_e decode_op(input logic [7:0] b);
        if (b[7])      return OP_DADDR;
        else if (b[6]) return OP_GADDR;
        else if (b[5]) return OP_FUNC;
        else if (b[4]) return OP_SHIFT;
        else if (b[3]) return OP_DISP;
        else if (b[2]) return OP_ENTRY;
        else if (b[1]) return OP_HOME;
        else if (b[0]) return OP_CLEAR;
        else           return OP_NONE;
    endfunction

endpackage

// File: rtl/charlcd_bus_sync.sv
// Samples the asynchronous host bus on clk. Emits a one-cycle strobe when
// the enable has fallen, with select, direction and data taken from the
// first sample stage. Assumes the host holds select/rw/data stable for at
// least one clock after the enable falls.
module charlcd_bus_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_in,
    input  logic       rs_in,
    input  logic       rw_in,
    input  logic [7:0] db_in,
    output logic       strobe,
    output logic       cap_rs,
    output logic       cap_rw,
    output logic [7:0] cap_db
);
    logic en_q1, en_q2;

    // Two-stage enable sampler plus a bus capture aligned with stage one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q1  <= 1'b0;
            en_q2  <= 1'b0;
            cap_rs <= 1'b0;
            cap_rw <= 1'b0;
            cap_db <= 8'h00;
        end else begin
            en_q1  <= en_in;
            en_q2  <= en_q1;
            cap_rs <= rs_in;
            cap_rw <= rw_in;
            cap_db <= db_in;
        end
    end

    // Falling edge seen between the two sample stages.
    always_comb strobe = en_q2 & ~en_q1;

endmodule

// File: rtl/charlcd_busy_timer.sv
// Down-counter behind the busy flag. A load sets the remaining cycles;
// busy is high while the count is non-zero. Assumes the owner never loads
// while busy.
module charlcd_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    // Load on accepted operation, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Flag follows the remaining count.
    always_comb busy = (cnt != '0);

    p_busy_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    p_no_load_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && cnt != '0));

endmodule

// File: rtl/charlcd_addr_ctr.sv
// Shared address counter for both RAMs. Priority: zero, load, step.
// Step wraps per target: glyph RAM in 6 bits, display RAM by line layout.
module charlcd_addr_ctr #(
    parameter int LINE_LEN = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zero,
    input  logic       ld,
    input  logic [6:0] ld_val,
    input  logic       ld_glyph,
    input  logic       step,
    input  logic       step_up,
    input  logic       two_line,
    output logic [6:0] ac,
    output logic       glyph_sel
);
    localparam logic [6:0] LINE2_BASE = 7'h40;
    localparam logic [6:0] L1_LAST    = 7'(LINE_LEN - 1);
    localparam logic [6:0] L2_LAST    = 7'(64 + LINE_LEN - 1);
    localparam logic [6:0] ONE_LAST   = 7'(2 * LINE_LEN - 1);

    logic [6:0] ac_step;

    // Next counter value for one step in the current target and mode.
    always_comb begin
        if (glyph_sel) begin
            ac_step = {1'b0, step_up ? ac[5:0] + 6'd1 : ac[5:0] - 6'd1};
        end else if (two_line) begin
            if (step_up)
                ac_step = (ac == L1_LAST) ? LINE2_BASE :
                          (ac == L2_LAST) ? 7'h00 : ac + 7'd1;
            else
                ac_step = (ac == LINE2_BASE) ? L1_LAST :
                          (ac == 7'h00) ? L2_LAST : ac - 7'd1;
        end else begin
            if (step_up) ac_step = (ac == ONE_LAST) ? 7'h00 : ac + 7'd1;
            else         ac_step = (ac == 7'h00) ? ONE_LAST : ac - 7'd1;
        end
    end

    // Counter and RAM-select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac        <= 7'h00;
            glyph_sel <= 1'b0;
        end else if (zero) begin
            ac        <= 7'h00;
            glyph_sel <= 1'b0;
        end else if (ld) begin
            ac        <= ld_val;
            glyph_sel <= ld_glyph;
        end else if (step) begin
            ac        <= ac_step;
        end
    end

    p_glyph_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_sel |-> !ac[6]);

    p_two_line_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !zero && !ld && step_up && two_line && !glyph_sel && ac == L1_LAST)
        |=> (ac == LINE2_BASE));

    p_one_line_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !zero && !ld && step_up && !two_line && !glyph_sel && ac == ONE_LAST)
        |=> (ac == 7'h00));

endmodule

// File: rtl/charlcd_ctrl.sv
// Character LCD controller core. Decodes host bus cycles into instructions
// and data accesses, owns the display and glyph RAMs, the mode flags and
// the busy timer. Busy lengths are given in clock cycles by parameters.
module charlcd_ctrl
    import charlcd_pkg::*;
#(
    parameter int LINE_LEN   = 40,
    parameter int GLYPH_SIZE = 64,
    parameter int LONG_CYC   = 76500,
    parameter int SHORT_CYC  = 1950,
    parameter int DATA_CYC   = 2150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rs,
    input  logic       bus_rw,
    input  logic       bus_en,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on
);
    localparam int DD_BYTES = 2 * LINE_LEN;
    localparam int MAX_A    = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int MAX_CYC  = (MAX_A > DATA_CYC) ? MAX_A : DATA_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int GA_W     = $clog2(GLYPH_SIZE);

    logic             strobe, c_rs, c_rw;
    logic [7:0]       c_db;
    logic             busy, glyph_sel;
    logic [6:0]       ac;
    op_e              op;
    logic             is_instr, is_wr, is_rd;
    logic             ac_zero, ac_ld, ac_ld_glyph, ac_step, ac_up;
    logic [6:0]       ac_ld_val;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             step_inc, shift_on, two_line, bus8, tall_font;
    logic             dd_ok;
    logic [6:0]       dd_idx;
    logic [7:0]       rd_byte;
    logic [7:0]       dd_mem [DD_BYTES];
    logic [7:0]       gl_mem [GLYPH_SIZE];

    charlcd_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .en_in(bus_en), .rs_in(bus_rs),
        .rw_in(bus_rw), .db_in(bus_din), .strobe(strobe),
        .cap_rs(c_rs), .cap_rw(c_rw), .cap_db(c_db)
    );

    // Classify the captured cycle; everything except status is dropped while busy.
    always_comb begin
        op       = decode_op(c_db);
        is_instr = strobe && !busy && !c_rs && !c_rw;
        is_wr    = strobe && !busy &&  c_rs && !c_rw;
        is_rd    = strobe && !busy &&  c_rs &&  c_rw;
    end

    // Counter control derived from the accepted operation.
    always_comb begin
        ac_zero     = is_instr && (op == OP_CLEAR || op == OP_HOME);
        ac_ld       = is_instr && (op == OP_GADDR || op == OP_DADDR);
        ac_ld_glyph = (op == OP_GADDR);
        ac_ld_val   = (op == OP_DADDR) ? c_db[6:0] : {1'b0, c_db[5:0]};
        ac_step     = is_wr || is_rd || (is_instr && op == OP_SHIFT && !c_db[3]);
        ac_up       = (is_wr || is_rd) ? step_inc : c_db[2];
    end

    charlcd_addr_ctr #(.LINE_LEN(LINE_LEN)) u_ac (
        .clk(clk), .rst_n(rst_n), .zero(ac_zero), .ld(ac_ld),
        .ld_val(ac_ld_val), .ld_glyph(ac_ld_glyph), .step(ac_step),
        .step_up(ac_up), .two_line(two_line), .ac(ac), .glyph_sel(glyph_sel)
    );

    // Busy length chosen by operation class.
    always_comb begin
        t_load = is_wr || is_rd || (is_instr && op != OP_NONE);
        if (is_wr || is_rd)
            t_val = CNT_W'(DATA_CYC);
        else if (op == OP_CLEAR || op == OP_HOME)
            t_val = CNT_W'(LONG_CYC);
        else
            t_val = CNT_W'(SHORT_CYC);
    end

    charlcd_busy_timer #(.CNT_W(CNT_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .busy(busy)
    );

    // Mode and display flags written by their instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_inc  <= 1'b1;
            shift_on  <= 1'b0;
            disp_on   <= 1'b0;
            cursor_on <= 1'b0;
            blink_on  <= 1'b0;
            bus8      <= 1'b1;
            two_line  <= 1'b0;
            tall_font <= 1'b0;
        end else if (is_instr) begin
            case (op)
                OP_ENTRY: begin
                    step_inc <= c_db[1];
                    shift_on <= c_db[0];
                end
                OP_DISP: begin
                    disp_on   <= c_db[2];
                    cursor_on <= c_db[1];
                    blink_on  <= c_db[0];
                end
                OP_FUNC: begin
                    bus8      <= c_db[4];
                    two_line  <= c_db[3];
                    tall_font <= c_db[2];
                end
                default: ;
            endcase
        end
    end

    // Map the counter to a physical display RAM cell for the line mode.
    always_comb begin
        if (two_line) begin
            dd_ok  = (ac[5:0] < 6'(LINE_LEN));
            dd_idx = ac[6] ? 7'(LINE_LEN) + {1'b0, ac[5:0]} : {1'b0, ac[5:0]};
        end else begin
            dd_ok  = (ac < 7'(DD_BYTES));
            dd_idx = ac;
        end
    end

    // Display RAM: blank fill on reset and clear, byte write on data write.
    always_ff @(posedge clk) begin
        if (!rst_n || (is_instr && op == OP_CLEAR)) begin
            for (int i = 0; i < DD_BYTES; i++) dd_mem[i] <= BLANK_CODE;
        end else if (is_wr && !glyph_sel && dd_ok) begin
            dd_mem[dd_idx] <= c_db;
        end
    end

    // Glyph RAM: zero on reset, byte write on data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GLYPH_SIZE; i++) gl_mem[i] <= 8'h00;
        end else if (is_wr && glyph_sel) begin
            gl_mem[ac[GA_W-1:0]] <= c_db;
        end
    end

    // Read path: byte at the counter in the selected RAM.
    always_comb begin
        if (glyph_sel)  rd_byte = gl_mem[ac[GA_W-1:0]];
        else if (dd_ok) rd_byte = dd_mem[dd_idx];
        else            rd_byte = 8'h00;
    end

    // Output mux driven straight from the host's select and direction lines.
    always_comb begin
        if (!bus_rw)     bus_dout = 8'h00;
        else if (bus_rs) bus_dout = rd_byte;
        else             bus_dout = {busy, ac};
    end

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ac) && $stable(glyph_sel));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_instr && op == OP_CLEAR) |=> (ac == 7'h00) && busy);

    p_status_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !c_rs && c_rw && !busy) |=> !busy);

endmodule

// File: tb/test_charlcd_ctrl.sv
module test_charlcd_ctrl;
    localparam int LONG  = 40;
    localparam int SHORT = 5;
    localparam int DATA  = 7;
    localparam int GAP   = LONG + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rs = 1'b0, rw = 1'b0, en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       d_on, c_on, b_on;
    int         total = 0, bad = 0;
    logic       finished = 1'b0;

    charlcd_ctrl #(.LINE_LEN(40), .GLYPH_SIZE(64), .LONG_CYC(LONG),
                   .SHORT_CYC(SHORT), .DATA_CYC(DATA)) i_charlcd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_rs(rs), .bus_rw(rw), .bus_en(en),
        .bus_din(din), .bus_dout(dout), .disp_on(d_on), .cursor_on(c_on),
        .blink_on(b_on)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // One enable pulse; returns on the negedge where enable went low.
    task automatic pulse(input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        rs = r; rw = w; din = d; en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
    endtask

    task automatic op(input logic r, input logic w, input logic [7:0] d);
        pulse(r, w, d);
        repeat (GAP) @(negedge clk);
    endtask

    task automatic status(output logic [7:0] v);
        rs = 1'b0; rw = 1'b1; #1; v = dout;
    endtask

    task automatic rdata(output logic [7:0] v);
        rs = 1'b1; rw = 1'b1; #1; v = dout;
        op(1'b1, 1'b1, 8'h00);
    endtask

    function automatic int nxt2(input int a, input bit up);
        if (up) return (a == 8'h27) ? 8'h40 : (a == 8'h67) ? 0 : a + 1;
        return (a == 8'h40) ? 8'h27 : (a == 0) ? 8'h67 : a - 1;
    endfunction

    function automatic int pos2(input int i);
        return (i < 40) ? i : 8'h40 + i - 40;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        status(v); chk("R1 status", v, 8'h00);
        chk("R1 flags", {d_on, c_on, b_on}, 0);
        rdata(v); chk("R1 blank ram", v, 8'h20);
        status(v); chk("R1 step up", v, 8'h01);

        // R2 decode by highest set bit
        op(0, 0, 8'h0F); chk("R2 disp 0F", {d_on, c_on, b_on}, 3'b111);
        op(0, 0, 8'h0A); chk("R2 disp 0A", {d_on, c_on, b_on}, 3'b010);
        op(0, 0, 8'h00); chk("R2 nop", {d_on, c_on, b_on}, 3'b010);
        op(0, 0, 8'h17); chk("R2 shift not disp", {d_on, c_on, b_on}, 3'b010);

        // R5 short busy window
        pulse(0, 0, 8'h0C);
        repeat (SHORT + 1) @(negedge clk);
        status(v); chk("R5 short busy", v[7], 1);
        @(negedge clk); status(v); chk("R5 short free", v[7], 0);
        chk("R2 disp 0C", {d_on, c_on, b_on}, 3'b100);

        // R9 R7 two-line write sweep over all 80 cells
        op(0, 0, 8'h38);
        op(0, 0, 8'h80);
        a = 0;
        for (int i = 0; i < 80; i++) begin
            op(1, 0, 8'((i * 7 + 3) & 8'hFF));
            a = nxt2(a, 1);
            status(v); chk("R9 inc wrap", v, a);
        end
        op(0, 0, 8'h80);
        for (int i = 0; i < 80; i++) begin
            rdata(v); chk("R7 dd readback", v, (i * 7 + 3) & 8'hFF);
        end

        // R5 data busy window
        pulse(1, 0, 8'h11);
        repeat (DATA + 1) @(negedge clk);
        status(v); chk("R5 data busy", v[7], 1);
        @(negedge clk); status(v); chk("R5 data free", v[7], 0);
        repeat (GAP) @(negedge clk);

        // R8 R9 step down across line gaps
        op(0, 0, 8'h04);
        op(0, 0, 8'hC0); rdata(v); status(v); chk("R9 dec 40", v, 8'h27);
        op(0, 0, 8'h80); rdata(v); status(v); chk("R9 dec 00", v, 8'h67);
        rdata(v); status(v); chk("R8 dec", v, 8'h66);

        // R10 one-line wrap
        op(0, 0, 8'h30); op(0, 0, 8'h06);
        op(0, 0, 8'hCF); op(1, 0, 8'h5A); status(v); chk("R10 inc 4F", v, 8'h00);
        op(0, 0, 8'hCF); rdata(v); chk("R10 cell 4F", v, 8'h5A);
        op(0, 0, 8'h04); op(0, 0, 8'h80); rdata(v);
        status(v); chk("R10 dec 00", v, 8'h4F);

        // R13 glyph RAM sweep and wrap
        op(0, 0, 8'h06); op(0, 0, 8'h40);
        for (int i = 0; i < 64; i++) begin
            op(1, 0, 8'(i ^ 8'h55));
            status(v); chk("R13 glyph ac", v, (i + 1) & 8'h3F);
        end
        for (int i = 0; i < 64; i++) begin
            rdata(v); chk("R7 glyph readback", v, i ^ 8'h55);
        end
        op(0, 0, 8'h7F); status(v); chk("R7 glyph 6 bits", v, 8'h3F);

        // R12 cursor and display shift
        op(0, 0, 8'h38); op(0, 0, 8'h85);
        op(0, 0, 8'h14); status(v); chk("R12 right", v, 8'h06);
        op(0, 0, 8'h10); status(v); chk("R12 left", v, 8'h05);
        op(0, 0, 8'h1C); status(v); chk("R12 disp shift", v, 8'h05);
        op(0, 0, 8'hA7); op(0, 0, 8'h14); status(v); chk("R12 wrap", v, 8'h40);
        op(0, 0, 8'h85); rdata(v); chk("R12 ram kept", v, (5 * 7 + 3) & 8'hFF);

        // R11 accesses during busy are dropped
        op(0, 0, 8'h85);
        pulse(1, 0, 8'h41);
        pulse(1, 0, 8'h42);
        repeat (GAP) @(negedge clk);
        status(v); chk("R11 ac once", v, 8'h06);
        op(0, 0, 8'h85); rdata(v); chk("R11 data kept", v, 8'h41);
        pulse(0, 0, 8'h08);
        pulse(0, 0, 8'h0F);
        repeat (GAP) @(negedge clk);
        chk("R11 flags kept", {d_on, c_on, b_on}, 3'b000);

        // R6 status read does not start busy
        pulse(0, 1, 8'h00);
        repeat (3) @(negedge clk);
        status(v); chk("R6 no busy", v, 8'h06);

        // R4 home
        op(0, 0, 8'h8A);
        pulse(0, 0, 8'h02);
        repeat (LONG + 1) @(negedge clk);
        status(v); chk("R4 busy long", v, 8'h80);
        @(negedge clk); status(v); chk("R4 free", v, 8'h00);
        op(0, 0, 8'h85); rdata(v); chk("R4 ram kept", v, 8'h41);

        // R3 clear with a dropped address instruction inside its busy window
        pulse(0, 0, 8'h01);
        pulse(0, 0, 8'h9F);
        repeat (LONG - 10) @(negedge clk);
        status(v); chk("R3 busy", v, 8'h80);
        repeat (20) @(negedge clk);
        status(v); chk("R3 ac zero", v, 8'h00);
        for (int i = 0; i < 80; i++) begin
            op(0, 0, 8'(8'h80 | pos2(i)));
            rdata(v); chk("R3 blank", v, 8'h20);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule